// File: doc/BRIEF.md
# PLL Frequency-Change Sequencer

This block is a hardware state machine that moves one of four per-cluster clock PLLs to a new output frequency without software stepping through the procedure. A one-cycle start pulse captures a cluster number and a frequency selector. The sequencer then acts as a master on a simple register bus (address, write data, read data, read strobe, write strobe, ready). It first switches the cluster clock onto its bypass source and holds the PLL and its post-divider in reset. It then programs the divider and loop-filter registers and releases the PLL core reset. Next it triggers a VCO update and polls the lock bit for a bounded time. Finally it releases the post-divider reset and switches the clock back to the oscillator output.

Control bits are changed by read-modify-write, so every other bit in those registers is left as it was. After the last step the sequencer reads the integer divider back and reports which selector is now in force. A PLL that fails to lock within the poll budget raises a sticky error flag, and the remaining steps still run. The analog PLL and its register file sit outside the block.

Top module: `pll_retune_seq`

## Requirements
- R1: After a start pulse, bus accesses occur in exactly this order. Bypass on (read then write 0xAC). Both resets asserted (read then write 0x70). Divider and loop writes (0x100, 0x104, 0x108, 0x10C). PLL core reset release (read then write 0x70). VCO update (read then write 0x80). Lock polls (reads of 0x84). Post-divider reset release (read then write 0x70). Bypass off (read then write 0xAC). Readback (read of 0x108).
- R2: Every address is the cluster base plus a register offset. The base is 0x66000000 + cluster × 0x2000 for clusters 0 to 3. Any larger cluster value uses the cluster-0 base. The base stays fixed for the whole sequence.
- R3: Selector code 1 (full) writes integer divider 0x78, code 2 (half) writes 0x3C, and code 3 (quarter) writes 0x1E. The divider goes into bits [9:0] of 0x108, and a post-divider of 1 goes into bits [15:12] of the same register. Code 0 skips all four divider and loop writes, and the other steps still run.
- R4: The fractional-divider registers at 0x100 and 0x104 are written with 0. The loop register at 0x10C is written with 0xC823. This value packs gain 3 at bit 0, gain 2 at bit 4, fast-lock gain 0 at bit 7 and reference info 50 at bit 10.
- R5: The resets in 0x70 are active low: the PLL core reset is bit 4 and the post-divider reset is bit 5. Asserting clears both bits. The core bit is set before the lock wait and the post bit after it. All other bits of 0x70 are preserved.
- R6: Bypass is bit 0 of 0xAC: the sequencer sets it first and clears it last. The VCO update sets bit 0 of 0x80. All other bits of both registers are preserved.
- R7: The lock wait reads bit 9 of 0x84 at most POLL_MAX times, and at least POLL_GAP cycles pass before each read. It stops at the first read that shows bit 9 set. When the budget runs out, lock_err is set and the sequence continues. lock_err is cleared by the next accepted start.
- R8: At the end of the sequence, sel_now is set from bits [9:0] of 0x108: 0x78 gives 1, 0x3C gives 2, 0x1E gives 3, and any other value gives 0.
- R9: Once raised, a read or write strobe holds its address, and for a write its data, until the cycle in which ready is high. That cycle completes the access.
- R10: busy rises the cycle after an accepted start and falls in the cycle that done pulses high for exactly one cycle. A start while busy is ignored. After reset busy, done, lock_err, sel_now and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a sequence |
| cluster | input | CL_W | Cluster number captured at start |
| freq_sel | input | 2 | Frequency selector captured at start (0 none, 1 full, 2 half, 3 quarter) |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid with ready |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ready | input | 1 | Access completes in a cycle where this is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| lock_err | output | 1 | Lock wait of the last sequence ran out |
| sel_now | output | 2 | Selector decoded from the programmed divider |

## Verification
The sequence is run with every selector code and with cluster numbers inside and outside the valid range. This separates the divider and skip paths and the base fallback. Lock responses arrive on the first poll, on a middle poll, exactly on the last allowed poll, one poll too late, and never. These cases separate the stop-on-lock path from the timeout path and expose an off-by-one in the poll budget. Random preset values in the control registers show whether read-modify-write keeps the untouched bits. A random preset divider register shows whether readback decodes an unrecognised value to 0. Random ready stalls and a start pulse issued mid-sequence test the bus hold rule and the rule that a start while busy is ignored.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    localparam int DATA_W = 32;
    localparam int NDIV_W = 10;

    typedef enum logic [1:0] {
        OP_RMW = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2
    } op_e;

    // Order of this list is the bring-up order (R1)
    typedef enum logic [3:0] {
        ST_BYP_ON, ST_RST_ON, ST_FRAC_LO, ST_FRAC_HI, ST_NDIV, ST_LOOP,
        ST_PLL_REL, ST_VCO_UPD, ST_POLL, ST_POST_REL, ST_BYP_OFF, ST_READBACK
    } step_e;

    typedef struct packed {
        op_e              op;
        logic [11:0]      off;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
    } acc_t;

    localparam logic [11:0] OFF_RST  = 12'h070;
    localparam logic [11:0] OFF_CMD  = 12'h080;
    localparam logic [11:0] OFF_STAT = 12'h084;
    localparam logic [11:0] OFF_BYP  = 12'h0AC;
    localparam logic [11:0] OFF_FLO  = 12'h100;
    localparam logic [11:0] OFF_FHI  = 12'h104;
    localparam logic [11:0] OFF_DIV  = 12'h108;
    localparam logic [11:0] OFF_LOOP = 12'h10C;

    localparam int BIT_PLL_RST  = 4;
    localparam int BIT_POST_RST = 5;
    localparam int BIT_LOCK     = 9;
    localparam int BIT_BYP      = 0;
    localparam int BIT_VCO_UPD  = 0;
    localparam int PDIV_LSB     = 12;
    localparam int PDIV_VAL     = 1;

    localparam logic [DATA_W-1:0] LOOP_WORD =
        (DATA_W'(3) << 0) | (DATA_W'(2) << 4) | (DATA_W'(0) << 7) | (DATA_W'(50) << 10);

    function automatic logic [NDIV_W-1:0] ndiv_of(logic [1:0] sel);
        case (sel)
            2'd1:    return NDIV_W'(10'h078);
            2'd2:    return NDIV_W'(10'h03C);
            2'd3:    return NDIV_W'(10'h01E);
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] sel_of(logic [DATA_W-1:0] word);
        case (word[NDIV_W-1:0])
            10'h078: return 2'd1;
            10'h03C: return 2'd2;
            10'h01E: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic acc_t step_acc(step_e s, logic [NDIV_W-1:0] ndiv);
        acc_t a;
        a.op   = OP_RMW;
        a.off  = OFF_RST;
        a.mask = '0;
        a.val  = '0;
        case (s)
            ST_BYP_ON:   begin a.off = OFF_BYP; a.mask = DATA_W'(1) << BIT_BYP; a.val = a.mask; end
            ST_RST_ON:   begin a.mask = (DATA_W'(1) << BIT_PLL_RST) | (DATA_W'(1) << BIT_POST_RST); end
            ST_FRAC_LO:  begin a.op = OP_WR; a.off = OFF_FLO; a.mask = '1; end
            ST_FRAC_HI:  begin a.op = OP_WR; a.off = OFF_FHI; a.mask = '1; end
            ST_NDIV:     begin
                a.op = OP_WR; a.off = OFF_DIV; a.mask = '1;
                a.val = DATA_W'(ndiv) | (DATA_W'(PDIV_VAL) << PDIV_LSB);
            end
            ST_LOOP:     begin a.op = OP_WR; a.off = OFF_LOOP; a.mask = '1; a.val = LOOP_WORD; end
            ST_PLL_REL:  begin a.mask = DATA_W'(1) << BIT_PLL_RST; a.val = a.mask; end
            ST_VCO_UPD:  begin a.off = OFF_CMD; a.mask = DATA_W'(1) << BIT_VCO_UPD; a.val = a.mask; end
            ST_POLL:     begin a.op = OP_RD; a.off = OFF_STAT; end
            ST_POST_REL: begin a.mask = DATA_W'(1) << BIT_POST_RST; a.val = a.mask; end
            ST_BYP_OFF:  begin a.off = OFF_BYP; a.mask = DATA_W'(1) << BIT_BYP; end
            ST_READBACK: begin a.op = OP_RD; a.off = OFF_DIV; end
            default:     ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/pll_retune_bus.sv
module pll_retune_bus
    import pll_retune_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] val,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready
);

    typedef enum logic [1:0] {B_IDLE, B_RD, B_WR} bstate_e;

    typedef struct packed {
        bstate_e           st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] hold;
        logic              done;
    } bus_s;

    bus_s q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            B_IDLE: if (req) begin
                d.op   = op;
                d.addr = addr;
                d.mask = mask;
                d.val  = val;
                d.hold = val;
                d.st   = (op == OP_WR) ? B_WR : B_RD;
            end
            B_RD: if (bus_ready) begin
                if (q.op == OP_RMW) begin
                    d.hold = (bus_rdata & ~q.mask) | (q.val & q.mask);
                    d.st   = B_WR;
                end else begin
                    d.hold = bus_rdata;
                    d.done = 1'b1;
                    d.st   = B_IDLE;
                end
            end
            B_WR: if (bus_ready) begin
                d.done = 1'b1;
                d.st   = B_IDLE;
            end
            default: d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: B_IDLE, op: OP_RMW, default: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_rd    = (q.st == B_RD);
    assign bus_wr    = (q.st == B_WR);
    assign bus_addr  = q.addr;
    assign bus_wdata = q.hold;
    assign acc_done  = q.done;
    assign acc_data  = q.hold;

    // R9: a stalled strobe keeps its address and data
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: rtl/pll_retune_gap.sv
module pll_retune_gap #(
    parameter int GAP = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        expire = run && (cnt_q == CW'(GAP - 1));
        cnt_d  = (run && !expire) ? cnt_q + CW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int               CL_W     = 3,
    parameter int               N_CL     = 4,
    parameter int               ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] BASE    = 32'h6600_0000,
    parameter logic [ADDR_W-1:0] STRIDE  = 32'h0000_2000,
    parameter int               POLL_MAX = 1500,
    parameter int               POLL_GAP = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CL_W-1:0]   cluster,
    input  logic [1:0]        freq_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready,
    output logic              busy,
    output logic              done,
    output logic              lock_err,
    output logic [1:0]        sel_now
);

    localparam int PW = $clog2(POLL_MAX + 1);

    typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT, F_GAP} fsm_e;

    typedef struct packed {
        fsm_e              fsm;
        step_e             step;
        logic [ADDR_W-1:0] base;
        logic [NDIV_W-1:0] ndiv;
        logic [PW-1:0]     polls;
        logic              err;
        logic [1:0]        sel;
        logic              done;
    } seq_s;

    seq_s q, d;

    acc_t              acc;
    logic              acc_done;
    logic [DATA_W-1:0] acc_data;
    logic              gap_expire;

    always_comb begin
        acc    = step_acc(q.step, q.ndiv);
        d      = q;
        d.done = 1'b0;
        case (q.fsm)
            F_IDLE: if (start) begin
                d.base  = (32'(cluster) < N_CL) ? BASE + STRIDE * ADDR_W'(cluster) : BASE;
                d.ndiv  = ndiv_of(freq_sel);
                d.step  = ST_BYP_ON;
                d.polls = '0;
                d.err   = 1'b0;
                d.fsm   = F_ISSUE;
            end
            F_ISSUE: d.fsm = F_WAIT;
            F_WAIT: if (acc_done) begin
                d.fsm = F_ISSUE;
                case (q.step)
                    ST_RST_ON:  d.step = (q.ndiv == '0) ? ST_PLL_REL : ST_FRAC_LO;
                    ST_VCO_UPD: begin
                        d.step  = ST_POLL;
                        d.polls = '0;
                        d.fsm   = F_GAP;
                    end
                    ST_POLL: begin
                        if (acc_data[BIT_LOCK]) begin
                            d.step = ST_POST_REL;
                        end else if (q.polls == PW'(POLL_MAX - 1)) begin
                            d.err  = 1'b1;
                            d.step = ST_POST_REL;
                        end else begin
                            d.polls = q.polls + PW'(1);
                            d.fsm   = F_GAP;
                        end
                    end
                    ST_READBACK: begin
                        d.sel  = sel_of(acc_data);
                        d.done = 1'b1;
                        d.fsm  = F_IDLE;
                    end
                    default: d.step = step_e'(q.step + 4'd1);
                endcase
            end
            F_GAP: if (gap_expire) d.fsm = F_ISSUE;
            default: d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{fsm: F_IDLE, step: ST_BYP_ON, default: '0};
        end else begin
            q <= d;
        end
    end

    pll_retune_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (q.fsm == F_ISSUE),
        .op        (acc.op),
        .addr      (q.base + ADDR_W'(acc.off)),
        .mask      (acc.mask),
        .val       (acc.val),
        .acc_done  (acc_done),
        .acc_data  (acc_data),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_ready (bus_ready)
    );

    pll_retune_gap #(.GAP(POLL_GAP)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (q.fsm == F_GAP),
        .expire (gap_expire)
    );

    assign busy     = (q.fsm != F_IDLE);
    assign done     = q.done;
    assign lock_err = q.err;
    assign sel_now  = q.sel;

    // R10: done is a single-cycle pulse and ends busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R2: the captured base cannot change mid-sequence
    p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.base));
    // R7: the poll counter never passes its budget
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.polls) < POLL_MAX);

endmodule

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;

    localparam int PM = 6;
    localparam int PG = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [2:0]  cluster = 0;
    logic [1:0]  freq_sel = 0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = 0;
    logic        bus_rd, bus_wr;
    logic        bus_ready = 0;
    logic        busy, done, lock_err;
    logic [1:0]  sel_now;

    always #10 clk = ~clk;

    pll_retune_seq #(.POLL_MAX(PM), .POLL_GAP(PG)) u_pll_retune_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cluster(cluster), .freq_sel(freq_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready),
        .busy(busy), .done(done), .lock_err(lock_err), .sel_now(sel_now));

    int checks = 0;
    int fails  = 0;
    logic [31:0] regs [logic [31:0]];
    int unsigned lock_cfg = 0;
    int unsigned poll_n = 0;
    int unsigned cyc = 0;
    int n = 0;
    bit    log_wr [64];
    logic [31:0] log_a [64];
    logic [31:0] log_d [64];
    int unsigned log_c [64];

    function automatic logic [31:0] rd_model(logic [31:0] a);
        if (a[11:0] == 12'h084)
            return 32'h100 | ((lock_cfg != 0 && poll_n + 1 >= lock_cfg) ? 32'h200 : 32'h0);
        return regs.exists(a) ? regs[a] : 32'h0;
    endfunction

    function automatic logic [31:0] exp_base(int unsigned cl);
        return (cl < 4) ? 32'h6600_0000 + cl * 32'h2000 : 32'h6600_0000;
    endfunction

    function automatic logic [31:0] exp_ndiv(logic [1:0] s);
        case (s)
            2'd1: return 32'h78;
            2'd2: return 32'h3C;
            2'd3: return 32'h1E;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] exp_dec(logic [31:0] v);
        case (v[9:0])
            10'h078: return 2'd1;
            10'h03C: return 2'd2;
            10'h01E: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        bus_ready <= ($urandom % 4) != 0;
        bus_rdata <= rd_model(bus_addr);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && (bus_rd || bus_wr) && bus_ready && n < 64) begin
            log_wr[n] = bus_wr;
            log_a[n]  = bus_addr;
            log_d[n]  = bus_wdata;
            log_c[n]  = cyc;
            n = n + 1;
            if (bus_wr) regs[bus_addr] = bus_wdata;
            if (bus_rd && bus_addr[11:0] == 12'h084) poll_n = poll_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int p;
    task automatic exp_acc(input bit wr, input logic [31:0] a, input logic [31:0] dv, input string tag);
        if (p >= n) begin
            chk(0, tag, 64'(n), 64'(p + 1));
        end else begin
            chk(log_wr[p] == wr && log_a[p] == a && (!wr || log_d[p] == dv), tag,
                {log_a[p], log_wr[p] ? log_d[p] : 32'h0}, {a, wr ? dv : 32'h0});
        end
        p++;
    endtask

    task automatic run(input int unsigned cl, input logic [1:0] sel, input int unsigned lk, input bit extra);
        logic [31:0] b, i70, iac, i80, r70;
        int unsigned k, last;
        bit ex_err, timeout;
        b   = exp_base(cl);
        i70 = $urandom; iac = $urandom; i80 = $urandom;
        regs[b + 32'h70] = i70; regs[b + 32'hAC] = iac; regs[b + 32'h80] = i80;
        regs[b + 32'h108] = ($urandom % 2) ? $urandom : {$urandom} & 32'hFFFF_FC00 | exp_ndiv(2'($urandom));
        lock_cfg = lk; poll_n = 0; n = 0; p = 0;
        @(negedge clk); start = 1; cluster = 3'(cl); freq_sel = sel;
        @(negedge clk); start = 0;
        chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        timeout = 1;
        for (int t = 0; t < 3000; t++) begin
            if (extra && t == 6) begin start = 1; cluster = 3'(cl ^ 1); freq_sel = ~sel; end
            else start = 0;
            if (done) begin timeout = 0; break; end
            @(negedge clk);
        end
        start = 0;
        chk(!timeout, "R10 done reached", 64'(timeout), 64'd0);
        chk(busy == 1'b0, "R10 busy low with done", 64'(busy), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        r70 = i70 & ~32'h30;
        exp_acc(0, b + 32'hAC, 0, "R1 R6 bypass read");
        exp_acc(1, b + 32'hAC, iac | 1, "R6 bypass set");
        exp_acc(0, b + 32'h70, 0, "R1 R5 reset read");
        exp_acc(1, b + 32'h70, r70, "R5 both resets on");
        if (sel != 0) begin
            exp_acc(1, b + 32'h100, 0, "R4 frac low");
            exp_acc(1, b + 32'h104, 0, "R4 frac high");
            exp_acc(1, b + 32'h108, exp_ndiv(sel) | 32'h1000, "R3 divider word");
            exp_acc(1, b + 32'h10C, 32'hC823, "R4 loop word");
        end
        exp_acc(0, b + 32'h70, 0, "R1 R3 reset read after divider");
        exp_acc(1, b + 32'h70, r70 | 32'h10, "R5 core reset release");
        exp_acc(0, b + 32'h80, 0, "R1 update read");
        exp_acc(1, b + 32'h80, i80 | 1, "R6 vco update");
        k = (lk >= 1 && lk <= PM) ? lk : PM;
        ex_err = !(lk >= 1 && lk <= PM);
        last = (p > 0 && p <= n) ? log_c[p - 1] : 0;
        for (int j = 0; j < int'(k); j++) begin
            if (p < n) begin
                chk(log_c[p] - last >= PG, "R7 poll gap", 64'(log_c[p] - last), 64'(PG));
                last = log_c[p];
            end
            exp_acc(0, b + 32'h84, 0, "R7 lock poll");
        end
        exp_acc(0, b + 32'h70, 0, "R1 post reset read");
        exp_acc(1, b + 32'h70, r70 | 32'h30, "R5 post reset release");
        exp_acc(0, b + 32'hAC, 0, "R1 bypass read 2");
        exp_acc(1, b + 32'hAC, iac & ~32'h1, "R6 bypass clear");
        exp_acc(0, b + 32'h108, 0, "R8 readback read");
        chk(n == p, "R1 R2 access count", 64'(n), 64'(p));
        chk(lock_err == ex_err, "R7 lock_err", 64'(lock_err), 64'(ex_err));
        chk(sel_now == exp_dec(regs[b + 32'h108]), "R8 sel_now", 64'(sel_now), 64'(exp_dec(regs[b + 32'h108])));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && lock_err == 0 && sel_now == 0 && bus_rd == 0 && bus_wr == 0,
            "R10 reset state", {busy, done, lock_err, sel_now, bus_rd, bus_wr}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        run(0, 2'd1, 1, 0);     // full speed, lock on first poll
        run(3, 2'd2, 3, 0);     // last cluster, half speed
        run(5, 2'd3, 2, 0);     // out-of-range cluster R2 fallback
        run(1, 2'd0, 2, 0);     // R3 skip of divider writes
        run(2, 2'd1, 0, 0);     // R7 never locks
        run(2, 2'd2, PM, 0);    // R7 lock on last allowed poll
        run(7, 2'd3, PM + 1, 0);// R7 one poll too late
        run(1, 2'd2, 1, 1);     // R10 start while busy ignored
        for (int r = 0; r < 20; r++)
            run($urandom % 8, 2'($urandom), $urandom % (PM + 2), ($urandom % 4) == 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule